// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Responder

This block is the interrupt-acknowledge side of a bus peripheral that sits in a priority daisy chain. It holds a small set of internal interrupt sources in fixed priority order and passes a chain-enable signal to lower-priority neighbours. It pulls that signal low when it is not enabled from upstream, when it has a source in service, or when it has a request pending during an acknowledge cycle.

An acknowledge cycle opens when the active-low acknowledge strobe falls. The chain then gets a configurable number of clock cycles to settle. On the synchronized falling edge of the active-low read strobe, the block decides whether the cycle belongs to it: it must be enabled from upstream and must hold an eligible pending source. When it claims the cycle, it latches the winning source into an in-service flag. If vector response is enabled, it also drives an 8-bit vector on the data bus, with the winner's index in the low bits, for as long as the read strobe stays low. A separate command clears the highest-priority in-service flag, which opens the chain again to lower-priority requests.

Top module: `irq_ack_responder`

## Requirements
- R1: While `rst_n` is low, all in-service flags, the data output enable and the data bus are 0, and the synchronized chain input resets to 0, so `chain_out_o` is 0. After release, `chain_out_o` follows the chain input again.
- R2: `chain_in_i`, `ack_n_i` and `rd_n_i` each pass through a two-flop synchronizer. A change on `chain_in_i` first shows on `chain_out_o` two rising clock edges after it is sampled.
- R3: `chain_out_o` is 1 only when the synchronized chain input is 1, no in-service flag is set, and it is not the case that the synchronized acknowledge is low while any request is pending.
- R4: A claim occurs only on a synchronized falling edge of the read strobe. At that edge the synchronized acknowledge must be low, the synchronized chain input must be high, and at least one eligible pending source must exist.
- R5: A read falling edge is not claimed unless the synchronized acknowledge has been low for at least `SETTLE` clock cycles.
- R6: After a claim with vector response enabled, `data_oe_o` is 1 from the next cycle for as long as the synchronized read strobe stays low. `data_o` is 0 whenever `data_oe_o` is 0.
- R7: The driven vector takes bits [7:2] from `vec_base_i` at the claim and bits [1:0] from the winning source index (0, 1 or 2).
- R8: Source 0 has the highest priority and source 2 the lowest. The winner is the lowest-index pending source for which no in-service flag is set at that index or a lower one.
- R9: A claim sets exactly the winner's in-service flag. That flag keeps its own source and all lower-priority sources from being claimed.
- R10: A one-cycle `clr_top_ius_i` clears the lowest-index in-service flag that is set. With no flag set, it has no effect.
- R11: When `vec_en_i` is 0 at the claim, the in-service flag is still set but `data_oe_o` stays 0.
- R12: A single read-low period claims at most once. The claim ends in the cycle after the synchronized read or acknowledge returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_i | input | 3 | Pending request per source, index 0 highest priority |
| chain_in_i | input | 1 | Upstream chain enable (asynchronous) |
| ack_n_i | input | 1 | Interrupt acknowledge strobe, active low (asynchronous) |
| rd_n_i | input | 1 | Read strobe, active low (asynchronous) |
| vec_en_i | input | 1 | Vector response enable |
| vec_base_i | input | 8 | Base vector; low index bits replaced by winner |
| clr_top_ius_i | input | 1 | Clear highest-priority in-service flag (one-cycle pulse) |
| chain_out_o | output | 1 | Downstream chain enable |
| data_o | output | 8 | Vector data |
| data_oe_o | output | 1 | Data bus output enable |
| ius_o | output | 3 | In-service flags |

## Verification
The hardest case to reach is a request that is pending but blocked. In that case a read edge arrives with the chain enabled upstream, yet an earlier in-service flag stops the claim. The stimulus builds that state by completing one acknowledge cycle for a mid-priority source and then running another cycle with the same and lower sources still requesting. Only after that does it raise a higher-priority source, and later use the clear command to release the flags one at a time. Read edges that come too soon after the acknowledge strobe are reached by dropping the read strobe one cycle into the acknowledge. A behavioural model tracks the synchronizer delay, the settle count and the claim on every clock.

// File: rtl/irq_ack_pkg.sv
// Package: shared constants for the interrupt acknowledge responder.
// Assumes a bus vector of 8 bits and active-low strobes that idle high.
package irq_ack_pkg;
    localparam int unsigned BUS_W = 8;
    // bundle of asynchronous control inputs, in synchronizer bit order
    typedef struct packed {
        logic chain;
        logic ack_n;
        logic rd_n;
    } async_in_t;
    localparam async_in_t ASYNC_IDLE = '{chain: 1'b0, ack_n: 1'b1, rd_n: 1'b1};
endpackage

// File: rtl/iack_sync.sv
// Module: two-flop synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independent; RST_VAL gives each bit's reset level.
module iack_sync #(
    parameter int unsigned W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // two-stage capture of the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/iack_select.sv
// Module: fixed-priority winner selection among internal sources.
// Index 0 is highest priority. An in-service flag blocks its own index
// and every higher index. Also reports the highest-priority set flag.
module iack_select #(
    parameter int unsigned NSRC  = 3,
    parameter int unsigned IDX_W = 2
) (
    input  logic [NSRC-1:0]  pend_i,
    input  logic [NSRC-1:0]  ius_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [NSRC-1:0]  top_ius_o
);
    // walk down the priority order, accumulating the in-service block
    always_comb begin
        logic blk;
        blk   = 1'b0;
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            blk = blk | ius_i[i];
            if (!blk && !any_o && pend_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    // isolate the lowest-index in-service flag
    assign top_ius_o = ius_i & ~(ius_i - NSRC'(1));
endmodule

// File: rtl/iack_ius.sv
// Module: in-service flag register.
// Sets the winner's flag on a claim and clears the highest-priority set
// flag on a clear command; both may occur in the same cycle.
module iack_ius #(
    parameter int unsigned NSRC  = 3,
    parameter int unsigned IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [IDX_W-1:0] set_idx_i,
    input  logic             clr_i,
    input  logic [NSRC-1:0]  top_mask_i,
    output logic [NSRC-1:0]  ius_o
);
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;

    // decode the set request into a one-hot vector
    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (set_i && set_idx_i == IDX_W'(i)) set_vec[i] = 1'b1;
        end
    end

    assign clr_vec = clr_i ? top_mask_i : '0;

    // flag storage
    always_ff @(posedge clk) begin
        if (!rst_n) ius_o <= '0;
        else        ius_o <= (ius_o & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/iack_ctrl.sv
// Module: acknowledge cycle control. Counts the settle interval after the
// acknowledge strobe falls, detects the read falling edge, decides the
// claim and drives the vector while the read strobe stays low.
// Assumes all strobe inputs are already synchronized.
module iack_ctrl #(
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned VEC_W  = 8,
    parameter int unsigned SETTLE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_n_s,
    input  logic             rd_n_s,
    input  logic             chain_s,
    input  logic             elig_any_i,
    input  logic [IDX_W-1:0] win_idx_i,
    input  logic             vec_en_i,
    input  logic [VEC_W-1:0] vec_base_i,
    output logic             take_o,
    output logic             data_oe_o,
    output logic [VEC_W-1:0] data_o
);
    localparam int unsigned CNT_W = $clog2(SETTLE + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE);

    logic [CNT_W-1:0] settle_q;
    logic             rd_prev_q;
    logic             claim_q;
    logic             drive_q;
    logic [VEC_W-1:0] vec_q;
    logic             settled;
    logic             rd_fall;

    assign settled = (settle_q == CNT_MAX);
    assign rd_fall = rd_prev_q && !rd_n_s;
    assign take_o  = rd_fall && !ack_n_s && settled && chain_s && elig_any_i;

    // settle interval counter, saturating while acknowledge is low
    always_ff @(posedge clk) begin
        if (!rst_n || ack_n_s) settle_q <= '0;
        else if (!settled)     settle_q <= settle_q + CNT_W'(1);
    end

    // previous read level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) rd_prev_q <= 1'b1;
        else        rd_prev_q <= rd_n_s;
    end

    // claim state and latched vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claim_q <= 1'b0;
            drive_q <= 1'b0;
            vec_q   <= '0;
        end else if (take_o) begin
            claim_q <= 1'b1;
            drive_q <= vec_en_i;
            vec_q   <= {vec_base_i[VEC_W-1:IDX_W], win_idx_i};
        end else if (rd_n_s || ack_n_s) begin
            claim_q <= 1'b0;
            drive_q <= 1'b0;
        end
    end

    assign data_oe_o = claim_q && drive_q && !rd_n_s;
    assign data_o    = data_oe_o ? vec_q : '0;
endmodule

// File: rtl/irq_ack_responder.sv
// Module: top of the daisy-chained interrupt acknowledge responder.
// Synchronizes the asynchronous strobes, registers source requests,
// forms the downstream chain enable, and ties together selection,
// claim control and in-service storage.
module irq_ack_responder #(
    parameter int unsigned NSRC   = 3,
    parameter int unsigned VEC_W  = 8,
    parameter int unsigned SETTLE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_req_i,
    input  logic             chain_in_i,
    input  logic             ack_n_i,
    input  logic             rd_n_i,
    input  logic             vec_en_i,
    input  logic [VEC_W-1:0] vec_base_i,
    input  logic             clr_top_ius_i,
    output logic             chain_out_o,
    output logic [VEC_W-1:0] data_o,
    output logic             data_oe_o,
    output logic [NSRC-1:0]  ius_o
);
    import irq_ack_pkg::*;

    localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    async_in_t       raw_in;
    async_in_t       syn_in;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] ius_q;
    logic [NSRC-1:0] top_mask;
    logic            elig_any;
    logic [IDX_W-1:0] win_idx;
    logic            take;

    assign raw_in = '{chain: chain_in_i, ack_n: ack_n_i, rd_n: rd_n_i};

    iack_sync #(.W(3), .RST_VAL(ASYNC_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    // registered pending state of the internal sources
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= src_req_i;
    end

    iack_select #(.NSRC(NSRC), .IDX_W(IDX_W)) u_sel (
        .pend_i    (pend_q),
        .ius_i     (ius_q),
        .any_o     (elig_any),
        .idx_o     (win_idx),
        .top_ius_o (top_mask)
    );

    iack_ctrl #(.IDX_W(IDX_W), .VEC_W(VEC_W), .SETTLE(SETTLE)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_n_s    (syn_in.ack_n),
        .rd_n_s     (syn_in.rd_n),
        .chain_s    (syn_in.chain),
        .elig_any_i (elig_any),
        .win_idx_i  (win_idx),
        .vec_en_i   (vec_en_i),
        .vec_base_i (vec_base_i),
        .take_o     (take),
        .data_oe_o  (data_oe_o),
        .data_o     (data_o)
    );

    iack_ius #(.NSRC(NSRC), .IDX_W(IDX_W)) u_ius (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (take),
        .set_idx_i  (win_idx),
        .clr_i      (clr_top_ius_i),
        .top_mask_i (top_mask),
        .ius_o      (ius_q)
    );

    // downstream chain enable
    assign chain_out_o = syn_in.chain && !(|ius_q) && !(!syn_in.ack_n && |pend_q);
    assign ius_o       = ius_q;
endmodule

// Checker: temporal properties of the responder, bound to the top.
module irq_ack_responder_chk #(
    parameter int unsigned NSRC  = 3,
    parameter int unsigned VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chain_in_i,
    input logic             clr_top_ius_i,
    input logic             chain_out_o,
    input logic [VEC_W-1:0] data_o,
    input logic             data_oe_o,
    input logic [NSRC-1:0]  ius_o
);
    // R3
    ius_blocks_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ius_o) |-> !chain_out_o);
    // R2
    chain_sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_out_o |-> $past(chain_in_i, 2));
    // R6
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe_o |-> (data_o == '0));
    // R7
    vec_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> (32'(data_o[1:0]) < NSRC));
    // R9
    single_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(ius_o & ~$past(ius_o)) <= 1));
    // R10
    clear_acts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_top_ius_i && |ius_o) |=> (ius_o != $past(ius_o)));
endmodule

bind irq_ack_responder irq_ack_responder_chk #(.NSRC(NSRC), .VEC_W(VEC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .chain_in_i    (chain_in_i),
    .clr_top_ius_i (clr_top_ius_i),
    .chain_out_o   (chain_out_o),
    .data_o        (data_o),
    .data_oe_o     (data_oe_o),
    .ius_o         (ius_o)
);

// File: tb/test_irq_ack_responder.sv
// Bench: behavioural reference model compared with the design every clock,
// plus directed checks per requirement.
module test_irq_ack_responder;
    localparam int SETTLE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_req = '0;
    logic       chain_in = 1'b1;
    logic       ack_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       vec_en = 1'b1;
    logic [7:0] vec_base = 8'hA0;
    logic       clr = 1'b0;
    logic       chain_out;
    logic [7:0] data;
    logic       data_oe;
    logic [2:0] ius;

    int n_run = 0;
    int n_fail = 0;
    bit saw_oe = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_ack_responder #(.NSRC(3), .VEC_W(8), .SETTLE(SETTLE)) i_irq_ack_responder (
        .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .chain_in_i(chain_in),
        .ack_n_i(ack_n), .rd_n_i(rd_n), .vec_en_i(vec_en), .vec_base_i(vec_base),
        .clr_top_ius_i(clr), .chain_out_o(chain_out), .data_o(data),
        .data_oe_o(data_oe), .ius_o(ius)
    );

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model state
    bit  q_chain[$] = '{0, 0};
    bit  q_ack[$]   = '{1, 1};
    bit  q_rd[$]    = '{1, 1};
    bit  m_rdprev = 1;
    int  m_cnt = 0;
    bit [2:0] m_pend = 0;
    bit [2:0] m_ius = 0;
    bit  m_claim = 0;
    bit  m_drive = 0;
    bit [7:0] m_vec = 0;

    // model update on each rising edge, computed from pre-edge state
    always @(posedge clk) begin
        bit chain_s, ack_s, rd_s, take;
        int win;
        bit blocked;
        bit [2:0] nxt;
        chain_s = q_chain[1]; ack_s = q_ack[1]; rd_s = q_rd[1];
        if (!rst_n) begin
            q_chain = '{0, 0}; q_ack = '{1, 1}; q_rd = '{1, 1};
            m_rdprev = 1; m_cnt = 0; m_pend = 0; m_ius = 0;
            m_claim = 0; m_drive = 0; m_vec = 0;
        end else begin
            win = -1; blocked = 0;
            for (int i = 0; i < 3; i++) begin
                if (m_ius[i]) blocked = 1;
                if (!blocked && win < 0 && m_pend[i]) win = i;
            end
            take = m_rdprev && !rd_s && !ack_s && (m_cnt == SETTLE) && chain_s && (win >= 0);
            nxt = m_ius;
            if (clr) begin
                for (int i = 0; i < 3; i++) if (m_ius[i]) begin nxt[i] = 0; break; end
            end
            if (take) nxt[win] = 1;
            if (take) begin
                m_claim = 1; m_drive = vec_en; m_vec = {vec_base[7:2], 2'(win)};
            end else if (rd_s || ack_s) begin
                m_claim = 0; m_drive = 0;
            end
            m_ius = nxt;
            m_cnt = ack_s ? 0 : ((m_cnt < SETTLE) ? m_cnt + 1 : m_cnt);
            m_rdprev = rd_s;
            m_pend = src_req;
            void'(q_chain.pop_back()); q_chain.push_front(chain_in);
            void'(q_ack.pop_back());   q_ack.push_front(ack_n);
            void'(q_rd.pop_back());    q_rd.push_front(rd_n);
        end
    end

    // compare outputs with the model away from the rising edge
    always @(negedge clk) begin
        bit e_chain, e_oe;
        if (!done) begin
            e_chain = q_chain[1] && (m_ius == 0) && !(!q_ack[1] && m_pend != 0);
            e_oe = m_claim && m_drive && !q_rd[1];
            chk("R3", chain_out, e_chain);
            chk("R6", data_oe, e_oe);
            chk("R7", data, e_oe ? m_vec : 0);
            chk("R9", ius, m_ius);
            if (data_oe) saw_oe = 1;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_cycle(int wait_c, int rd_len);
        saw_oe = 0;
        ack_n = 0; step(wait_c);
        rd_n = 0;  step(rd_len);
        rd_n = 1;  step(3);
        ack_n = 1; step(4);
    endtask

    task automatic clr_pulse();
        clr = 1; step(1); clr = 0; step(2);
    endtask

    initial begin
        step(3);
        // R1 reset state
        chk("R1", ius, 0); chk("R1", data_oe, 0); chk("R1", data, 0); chk("R1", chain_out, 0);
        rst_n = 1;
        step(2);
        chk("R1", chain_out, 1);
        // R2 two-clock synchronizer delay on chain input
        chain_in = 0; step(1);
        chk("R2", chain_out, 1);
        step(1);
        chk("R2", chain_out, 0);
        chain_in = 1; step(3);
        // R3 pending without acknowledge keeps chain open, acknowledge closes it
        src_req = 3'b110; step(3);
        chk("R3", chain_out, 1);
        ack_n = 0; step(3);
        chk("R3", chain_out, 0);
        ack_n = 1; step(3);
        // R4 R8 claim of source 1 over source 2, vector driven
        ack_cycle(8, 4);
        chk("R9", ius, 3'b010);
        chk("R6", saw_oe, 1);
        chk("R12", data_oe, 0);
        // R9 in-service source 1 blocks sources 1 and 2
        ack_cycle(8, 4);
        chk("R9", ius, 3'b010);
        chk("R9", saw_oe, 0);
        // R8 higher-priority source 0 still wins
        src_req = 3'b111; step(2);
        ack_cycle(8, 4);
        chk("R8", ius, 3'b011);
        // R10 clear highest first, then next, then no effect
        clr_pulse(); chk("R10", ius, 3'b010);
        clr_pulse(); chk("R10", ius, 3'b000);
        clr_pulse(); chk("R10", ius, 3'b000);
        // R4 chain input low prevents claim
        chain_in = 0; step(3);
        ack_cycle(8, 4);
        chk("R4", ius, 0);
        chain_in = 1; step(3);
        // R4 read without acknowledge is not a claim
        rd_n = 0; step(4); rd_n = 1; step(4);
        chk("R4", ius, 0);
        // R5 read edge before settle interval
        ack_cycle(1, 3);
        chk("R5", ius, 0);
        // R11 vector response disabled
        vec_en = 0; vec_base = 8'h5C;
        ack_cycle(8, 4);
        chk("R11", ius, 3'b001);
        chk("R11", saw_oe, 0);
        vec_en = 1;
        clr_pulse();
        // R12 long read low claims once; R7 new base
        src_req = 3'b100;
        step(2);
        ack_cycle(8, 10);
        chk("R12", ius, 3'b100);
        clr_pulse();
        // mixed stimulus, compared by the model
        for (int k = 0; k < 400; k++) begin
            src_req  = 3'($urandom);
            chain_in = ($urandom % 8) != 0;
            ack_n    = ($urandom % 4) != 0 ? ack_n : ~ack_n;
            rd_n     = ($urandom % 3) != 0 ? rd_n : ~rd_n;
            vec_en   = 1'($urandom);
            vec_base = 8'($urandom);
            clr      = ($urandom % 10) == 0;
            step(1);
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule